// File: doc/BRIEF.md
# Register-Driven I2C Byte Master

This block is a single-master I2C controller that software steers one byte at a time through a small bank of byte-wide registers. Software sets the SCL rate with a 16-bit prescaler, turns the core on, loads a byte and writes a command. The command can ask for a start or repeated start, a byte write, a byte read with a chosen acknowledge, a stop, or a combination of these. The block then runs that step on the bus and reports the outcome in a status register.

SCL and SDA are open-drain. For each line the block has an input and a drive-low enable. Status shows the acknowledge that came back, whether the bus is busy, whether arbitration was lost, whether a transfer is running, and whether an interrupt is pending. The interrupt output follows the pending flag.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, status and control read 0x00, both prescaler bytes read 0xFF, both line enables are low and irq is low.
- R2: Register offsets: 0 is the prescaler low byte and 2 the high byte. Offset 4 is control: bit 7 enables the core and bit 6 enables the interrupt. Offset 6 is data: a write loads the transmit byte and a read returns the last received byte. Offset 8 takes commands on write and returns status on read. Status bit 7 is the received acknowledge, bit 6 bus-busy, bit 5 arbitration-lost, bit 1 transfer-in-progress and bit 0 interrupt-pending. Status bits 4 to 2 read 0.
- R3: While control bit 7 is clear, both lines are released and command writes have no effect.
- R4: Command bit 7 generates a START, with SDA falling while SCL is high. This works from an idle bus and, without a stop in between, as a repeated start. Bus-busy sets when a START is seen on the lines.
- R5: Command bit 4 shifts the data byte out MSB first, then releases SDA for a ninth bit and stores the line value in status bit 7 (1 means NACK). If bits 5 and 4 are both set, the write takes precedence.
- R6: Command bit 5 receives eight bits MSB first with SDA released. On the ninth bit it drives ACK (low) when command bit 3 is 0 and NACK (released) when it is 1. The byte is then returned by a data-register read.
- R7: Command bit 6 generates a STOP, with SDA rising while SCL is high. Combined with a read or write, the STOP follows the ninth bit. Bus-busy clears when a STOP is seen on the lines.
- R8: Transfer-in-progress is high from the cycle after an accepted command until the whole command is finished. Command bits clear themselves, so the bus stays quiet afterwards.
- R9: When a command finishes or arbitration is lost with control bit 6 set, interrupt-pending sets and irq rises. Writing command bit 0 clears it.
- R10: One SCL period within a byte lasts 5 × (prescaler + 1) clock cycles.
- R11: If SDA is read low at a bit where the block sent a 1, the block sets arbitration-lost, releases both lines and ends the command.
- R12: If SCL stays low after the block releases it, the block waits and then resumes once SCL goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| irq | output | 1 | Interrupt request |
| scl_i | input | 1 | SCL line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench uses a behavioural target on the wired-AND bus that acknowledges one address, records written bytes and serves read bytes. A repeated start must leave bus-busy set. If it dropped, the flag would be tracking commands and not the line conditions. A read ended with NACK must release SDA on the ninth bit. A master that always sent ACK would keep the target driving data, and the STOP would then fail. A second driver pulls SDA low while a 0xFF byte goes out. This must flag lost arbitration and release both lines, not finish the byte. An external hold on SCL must stall the bit sequence. A design that ignored the hold would read bits that were never valid.

// File: rtl/i2c_byte_master.sv
`timescale 1ns/1ps
module i2c_byte_master #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq,
  input  logic          scl_i,
  output logic          scl_oe,
  input  logic          sda_i,
  output logic          sda_oe
);
  localparam logic [AW-1:0] A_PLO = AW'(0);
  localparam logic [AW-1:0] A_PHI = AW'(2);
  localparam logic [AW-1:0] A_CTL = AW'(4);
  localparam logic [AW-1:0] A_DAT = AW'(6);
  localparam logic [AW-1:0] A_CMD = AW'(8);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BIT, S_STOP} st_t;

  st_t         st;
  logic [15:0] presc, cnt;
  logic        en, ie;
  logic [7:0]  txd, rxd, sh;
  logic [2:0]  step;
  logic [3:0]  bcnt;
  logic        c_sto, c_rd, c_wr, c_nack;
  logic        rxack, busy, al, ip;
  logic        scl_q, sda_q;
  logic        unused_bits;

  wire tip    = (st != S_IDLE);
  wire tick   = tip && (cnt == 16'd0);
  wire hold   = !scl_oe && !scl_i;
  wire adv    = tick && !hold;
  wire cmd_go = reg_we && (reg_addr == A_CMD) && en && !tip && (|reg_wdata[7:4]);
  assign unused_bits = ^reg_wdata[2:1];
  assign irq = ip;

  always_comb begin
    case (reg_addr)
      A_PLO:   reg_rdata = presc[7:0];
      A_PHI:   reg_rdata = presc[15:8];
      A_CTL:   reg_rdata = {en, ie, 6'd0};
      A_DAT:   reg_rdata = rxd;
      A_CMD:   reg_rdata = {rxack, busy, al, 3'd0, tip, ip};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; presc <= 16'hFFFF; cnt <= 16'hFFFF;
      en <= 1'b0; ie <= 1'b0; txd <= 8'h00; rxd <= 8'h00; sh <= 8'h00;
      step <= 3'd0; bcnt <= 4'd0;
      c_sto <= 1'b0; c_rd <= 1'b0; c_wr <= 1'b0; c_nack <= 1'b0;
      rxack <= 1'b0; busy <= 1'b0; al <= 1'b0; ip <= 1'b0;
      scl_q <= 1'b1; sda_q <= 1'b1; scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (scl_q && scl_i && sda_q && !sda_i)      busy <= 1'b1;
      else if (scl_q && scl_i && !sda_q && sda_i) busy <= 1'b0;

      if (reg_we) begin
        case (reg_addr)
          A_PLO: presc[7:0]  <= reg_wdata;
          A_PHI: presc[15:8] <= reg_wdata;
          A_CTL: begin en <= reg_wdata[7]; ie <= reg_wdata[6]; end
          A_DAT: txd <= reg_wdata;
          A_CMD: if (en && reg_wdata[0]) ip <= 1'b0;
          default: ;
        endcase
      end

      cnt <= (!tip || cnt == 16'd0) ? presc : cnt - 16'd1;

      if (!en) begin
        st <= S_IDLE; scl_oe <= 1'b0; sda_oe <= 1'b0;
      end else if (cmd_go) begin
        c_sto  <= reg_wdata[6];
        c_wr   <= reg_wdata[4];
        c_rd   <= reg_wdata[5] & ~reg_wdata[4];
        c_nack <= reg_wdata[3];
        al <= 1'b0; step <= 3'd0; bcnt <= 4'd0; sh <= txd;
        st <= reg_wdata[7] ? S_START : (|reg_wdata[5:4]) ? S_BIT : S_STOP;
      end else if (adv) begin
        step <= (step == 3'd4) ? 3'd0 : step + 3'd1;
        case (st)
          S_START: case (step)
            3'd0: sda_oe <= 1'b0;
            3'd1: scl_oe <= 1'b0;
            3'd2: sda_oe <= 1'b1;
            3'd4: begin
              scl_oe <= 1'b1;
              if (c_wr || c_rd) st <= S_BIT;
              else if (c_sto)   st <= S_STOP;
              else begin st <= S_IDLE; if (ie) ip <= 1'b1; end
            end
            default: ;
          endcase
          S_BIT: case (step)
            3'd0: sda_oe <= (bcnt == 4'd8) ? (c_rd & ~c_nack) : (c_wr & ~sh[7]);
            3'd2: scl_oe <= 1'b0;
            3'd3: begin
              if (bcnt == 4'd8) begin
                if (c_wr) rxack <= sda_i;
              end else if (c_wr && sh[7] && !sda_i) begin
                al <= 1'b1; scl_oe <= 1'b0; sda_oe <= 1'b0; st <= S_IDLE;
                if (ie) ip <= 1'b1;
              end else begin
                sh <= {sh[6:0], sda_i};
              end
            end
            3'd4: begin
              scl_oe <= 1'b1;
              if (bcnt == 4'd8) begin
                bcnt <= 4'd0;
                if (c_rd) rxd <= sh;
                if (c_sto) st <= S_STOP;
                else begin st <= S_IDLE; if (ie) ip <= 1'b1; end
              end else begin
                bcnt <= bcnt + 4'd1;
              end
            end
            default: ;
          endcase
          S_STOP: case (step)
            3'd0: scl_oe <= 1'b1;
            3'd1: sda_oe <= 1'b1;
            3'd2: scl_oe <= 1'b0;
            3'd3: sda_oe <= 1'b0;
            3'd4: begin st <= S_IDLE; if (ie) ip <= 1'b1; end
            default: ;
          endcase
          default: ;
        endcase
      end
    end
  end

  a_r3_lines_released: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_oe && !sda_oe));
  a_r3_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && reg_we && reg_addr == A_CMD) |=> !tip);
  a_r4_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_START && st != S_START && $past(en)) |-> busy);
  a_r5_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_BIT && $past(en) && !$stable(sda_oe)) |-> $past(scl_oe));
  a_r8_tip_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (en && reg_we && reg_addr == A_CMD && !tip && reg_wdata[4]) |=> tip);
  a_r9_ip_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tip) && $past(ie) && $past(en)) |-> ip);
  a_r11_al_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(al) |-> (!scl_oe && !sda_oe && !tip));
endmodule

// File: tb/i2c_byte_master_tb.sv
`timescale 1ns/1ps
module i2c_byte_master_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq, scl_oe, sda_oe;
  logic slv_low = 1'b0, arb_low = 1'b0, stretch = 1'b0;
  logic scl_w, sda_w;
  int n_chk = 0, n_fail = 0;
  int cyc = 0, last_rise = 0, prev_rise = 0, n_rise = 0;

  assign scl_w = ~(scl_oe | stretch);
  assign sda_w = ~(sda_oe | slv_low | arb_low);

  i2c_byte_master #(.AW(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_i(scl_w), .scl_oe(scl_oe), .sda_i(sda_w), .sda_oe(sda_oe));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge scl_oe) begin prev_rise = last_rise; last_rise = cyc; n_rise++; end

  // behavioural target at address 0x50
  localparam logic [6:0] SLV = 7'h50;
  function automatic logic [7:0] rdgen(int i);
    return 8'h96 ^ 8'(i * 37);
  endfunction
  int s_state = 0; // 0 idle, 1 addr, 2 write, 3 read
  int bitcnt = 0, rd_idx = 0, start_cnt = 0, stop_cnt = 0, wr_cnt = 0;
  logic [7:0] shreg = 8'h00, addr_last = 8'h00, wr_last = 8'h00, rb;
  logic mack = 1'b0;
  logic pscl = 1'b1, psda = 1'b1;

  always @(scl_w, sda_w) begin
    if (scl_w && pscl && psda && !sda_w) begin
      start_cnt++; s_state = 1; bitcnt = 0; slv_low = 1'b0;
    end else if (scl_w && pscl && !psda && sda_w) begin
      stop_cnt++; s_state = 0; slv_low = 1'b0;
    end else if (scl_w && !pscl) begin
      if (s_state == 1 || s_state == 2) begin
        if (bitcnt < 8) shreg = {shreg[6:0], sda_w};
        bitcnt++;
      end else if (s_state == 3) begin
        if (bitcnt == 8) mack = sda_w;
        bitcnt++;
      end
    end else if (!scl_w && pscl) begin
      if (s_state == 1) begin
        if (bitcnt == 8) begin
          addr_last = shreg;
          if (shreg[7:1] == SLV) slv_low = 1'b1; else s_state = 0;
        end else if (bitcnt == 9) begin
          bitcnt = 0;
          if (addr_last[0]) begin
            s_state = 3; rd_idx = 0; rb = rdgen(0); slv_low = ~rb[7];
          end else begin
            s_state = 2; slv_low = 1'b0;
          end
        end
      end else if (s_state == 2) begin
        if (bitcnt == 8) begin wr_last = shreg; wr_cnt++; slv_low = 1'b1; end
        else if (bitcnt == 9) begin bitcnt = 0; slv_low = 1'b0; end
      end else if (s_state == 3) begin
        if (bitcnt >= 1 && bitcnt <= 7) begin rb = rdgen(rd_idx); slv_low = ~rb[7-bitcnt]; end
        else if (bitcnt == 8) slv_low = 1'b0;
        else if (bitcnt == 9) begin
          bitcnt = 0;
          if (!mack) begin rd_idx++; rb = rdgen(rd_idx); slv_low = ~rb[7]; end
          else begin s_state = 0; slv_low = 1'b0; end
        end
      end
    end
    pscl = scl_w; psda = sda_w;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 8000; i++) begin
      rd_reg(4'd8, s);
      if (!s[1]) break;
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd_reg(4'd8, d); chk(d == 8'h00, "R1 status", d, 0);
    rd_reg(4'd0, d); chk(d == 8'hFF, "R1 prescaler low", d, 8'hFF);
    rd_reg(4'd2, d); chk(d == 8'hFF, "R1 prescaler high", d, 8'hFF);
    rd_reg(4'd4, d); chk(d == 8'h00, "R1 control", d, 0);
    chk(!scl_oe && !sda_oe && !irq, "R1 lines and irq", {scl_oe, sda_oe, irq}, 0);
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    wr_reg(4'd0, 8'd2); wr_reg(4'd2, 8'd0);
    rd_reg(4'd0, d); chk(d == 8'd2, "R2 prescaler low", d, 2);
    rd_reg(4'd2, d); chk(d == 8'd0, "R2 prescaler high", d, 0);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    int r0 = n_rise;
    wr_reg(4'd6, 8'hA0);
    wr_reg(4'd8, 8'h90);
    repeat (200) @(negedge clk);
    rd_reg(4'd8, d); chk(d == 8'h00, "R3 command ignored", d, 0);
    chk(n_rise == r0 && start_cnt == 0 && !scl_oe && !sda_oe, "R3 lines idle", n_rise - r0, 0);
  endtask

  task automatic t_addr_write();
    logic [7:0] d;
    int r0;
    wr_reg(4'd4, 8'hC0);
    rd_reg(4'd4, d); chk(d == 8'hC0, "R2 control readback", d, 8'hC0);
    wr_reg(4'd6, 8'hA0);
    wr_reg(4'd8, 8'h90);
    rd_reg(4'd8, d); chk(d[1], "R8 tip after accept", d, 8'h02);
    wait_idle();
    chk(start_cnt == 1, "R4 start seen", start_cnt, 1);
    chk(addr_last == 8'hA0, "R5 address byte", addr_last, 8'hA0);
    rd_reg(4'd8, d); chk(d == 8'h41, "R5 status ack busy ip", d, 8'h41);
    chk(irq, "R9 irq", irq, 1);
    chk(last_rise - prev_rise == 15, "R10 period presc 2", last_rise - prev_rise, 15);
    wr_reg(4'd8, 8'h01);
    rd_reg(4'd8, d); chk(d == 8'h40 && !irq, "R9 iack clears", d, 8'h40);
    r0 = n_rise;
    repeat (300) @(negedge clk);
    chk(n_rise == r0, "R8 command self-clears", n_rise - r0, 0);
  endtask

  task automatic t_write_stop();
    logic [7:0] d;
    wr_reg(4'd6, 8'h3C);
    wr_reg(4'd8, 8'h50);
    wait_idle();
    chk(wr_last == 8'h3C, "R5 data byte", wr_last, 8'h3C);
    chk(stop_cnt == 1, "R7 stop seen", stop_cnt, 1);
    rd_reg(4'd8, d); chk(d == 8'h01, "R7 busy cleared", d, 8'h01);
    wr_reg(4'd8, 8'h01);
  endtask

  task automatic t_nack();
    logic [7:0] d;
    wr_reg(4'd6, 8'hB0);
    wr_reg(4'd8, 8'h90);
    wait_idle();
    rd_reg(4'd8, d); chk(d[7] == 1'b1, "R5 nack reported", d, 8'hC1);
    wr_reg(4'd8, 8'h41);
    wait_idle();
    rd_reg(4'd8, d); chk(d[6] == 1'b0, "R7 stop after nack", d, 8'h81);
    wr_reg(4'd8, 8'h01);
  endtask

  task automatic t_read();
    logic [7:0] d;
    int s0 = start_cnt;
    wr_reg(4'd6, 8'hA0); wr_reg(4'd8, 8'h90); wait_idle();
    wr_reg(4'd6, 8'h11); wr_reg(4'd8, 8'h10); wait_idle();
    wr_reg(4'd6, 8'hA1); wr_reg(4'd8, 8'h90); wait_idle();
    chk(start_cnt == s0 + 2, "R4 repeated start", start_cnt - s0, 2);
    rd_reg(4'd8, d); chk(d[6] && !d[7], "R4 busy kept over restart", d, 8'h41);
    wr_reg(4'd8, 8'h20); wait_idle();
    rd_reg(4'd6, d); chk(d == rdgen(0), "R6 first read byte", d, rdgen(0));
    chk(mack == 1'b0, "R6 master ack", mack, 0);
    wr_reg(4'd8, 8'h68); wait_idle();
    rd_reg(4'd6, d); chk(d == rdgen(1), "R6 second read byte", d, rdgen(1));
    chk(mack == 1'b1, "R6 master nack", mack, 1);
    rd_reg(4'd8, d); chk(d[6] == 1'b0, "R7 read then stop", d, 8'h01);
    wr_reg(4'd8, 8'h01);
  endtask

  task automatic t_rate();
    wr_reg(4'd0, 8'd4);
    wr_reg(4'd6, 8'hA0); wr_reg(4'd8, 8'h90); wait_idle();
    chk(last_rise - prev_rise == 25, "R10 period presc 4", last_rise - prev_rise, 25);
    wr_reg(4'd0, 8'd2);
  endtask

  task automatic t_stretch();
    logic [7:0] d;
    int r0;
    wr_reg(4'd6, 8'h55);
    wr_reg(4'd8, 8'h10);
    @(posedge scl_oe);
    @(negedge clk); stretch = 1'b1;
    r0 = n_rise;
    repeat (300) @(negedge clk);
    rd_reg(4'd8, d);
    chk(d[1] && !scl_oe && n_rise == r0, "R12 waits for scl", {d[1], scl_oe}, 2'b10);
    stretch = 1'b0;
    wait_idle();
    chk(wr_last == 8'h55, "R12 byte after wait", wr_last, 8'h55);
    wr_reg(4'd8, 8'h41); wait_idle();
  endtask

  task automatic t_arb();
    logic [7:0] d;
    wr_reg(4'd6, 8'hA0); wr_reg(4'd8, 8'h90); wait_idle();
    arb_low = 1'b1;
    wr_reg(4'd6, 8'hFF); wr_reg(4'd8, 8'h10); wait_idle();
    rd_reg(4'd8, d);
    chk(d[5] && !d[1] && d[0], "R11 arbitration lost", d, 8'h61);
    chk(!scl_oe && !sda_oe, "R11 lines released", {scl_oe, sda_oe}, 0);
    @(negedge clk); arb_low = 1'b0;
    repeat (4) @(negedge clk);
    rd_reg(4'd8, d); chk(d[6] == 1'b0, "R7 external stop clears busy", d, 8'h21);
    wr_reg(4'd8, 8'h01);
  endtask

  task automatic t_disable_end();
    wr_reg(4'd6, 8'hA0); wr_reg(4'd8, 8'h90);
    repeat (40) @(negedge clk);
    wr_reg(4'd4, 8'h00);
    @(negedge clk);
    chk(!scl_oe && !sda_oe, "R3 disable releases lines", {scl_oe, sda_oe}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_disabled();
    t_addr_write();
    t_write_stop();
    t_nack();
    t_read();
    t_rate();
    t_stretch();
    t_arb();
    t_disable_end();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule